// File: doc/BRIEF.md
# Linked-List DMA Descriptor Chain Controller

This block is the per-channel sequencer that walks a linked list of DMA command descriptors. Software writes the 8-byte-aligned physical address of a descriptor into the chain address register. A nonzero write arms the chain and marks the channel active. If the channel is idle, the write also starts the first descriptor fetch at once. Each descriptor is four 64-bit words: the next-chain pointer, the source address, the destination address and the byte count. The controller reads the four words over a valid/ready memory-read port and presents them on a one-cycle load strobe to the channel registers.

While a transfer runs, the data engine reports completion on `xfer_done`. If chaining is still enabled, the controller fetches the descriptor at the address now held in the register. Otherwise it clears the active flag and goes idle. A descriptor whose next-chain field is zero ends the list. The register then keeps the address of that last descriptor, chaining is disarmed, and the channel stays active until the final transfer ends.

The state machine has five states. In `ST_IDLE` the channel is inactive. In `ST_RUN` a descriptor's transfer is in progress. In `ST_REQ` one word read is being requested. In `ST_RSP` the controller waits for that word. `ST_LOAD` is the single cycle in which the descriptor is handed over. The transitions are as follows:
- `ST_IDLE`→`ST_REQ` on an accepted nonzero write.
- `ST_RUN`→`ST_REQ` on `xfer_done` with chaining armed.
- `ST_RUN`→`ST_IDLE` on `xfer_done` with chaining disarmed.
- `ST_REQ`→`ST_RSP` on request handshake.
- `ST_RSP`→`ST_REQ` on a response for words 0 to 2.
- `ST_RSP`→`ST_LOAD` on the response for word 3.
- `ST_LOAD`→`ST_RUN` unconditionally.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, `chain_en`, `xfer_act`, `rd_req_valid`, `desc_load` and `wr_dropped` are all 0.
- R2: `sw_rd_data` returns the chain address field in bits 35:3, with bits 63:36 and 2:0 always 0. A write stores `sw_wr_data[35:3]` and discards the other bits. The new value is visible in the cycle after the write.
- R3: A write whose bits 35:3 are nonzero, accepted outside a fetch, sets `chain_en` and `xfer_act` in the next cycle. If the channel was idle, it also starts a descriptor fetch at the written address.
- R4: A write whose bits 35:3 are zero, accepted outside a fetch, clears `chain_en` and leaves `xfer_act` unchanged.
- R5: A fetch issues four read requests, one at a time, at addresses A, A+8, A+16 and A+24, where A is the chain address. Each request after the first follows the response to the previous one, and `rd_req_valid` is low while a response is awaited.
- R6: One cycle after the fourth response, `desc_load` is high for exactly one cycle. In that cycle `desc_src` = word1[35:0], `desc_dst` = word2[35:0] and `desc_cnt` = word3[31:0].
- R7: If word0[35:3] is nonzero, the chain address becomes that value after the load, and the next `xfer_done` starts a fetch from it.
- R8: If word0[35:3] is zero, the chain address keeps the address of the descriptor just read, `chain_en` is cleared, and `xfer_act` stays 1.
- R9: `xfer_done` while running with `chain_en` clear clears `xfer_act` and returns to idle with no read request.
- R10: A write from the first request of a fetch through its load cycle does not change the chain address or flags. `wr_dropped` is 1 for one cycle, in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe for the chain address register |
| sw_wr_data | input | 64 | Software write data |
| sw_rd_data | output | 64 | Chain address register readback |
| xfer_done | input | 1 | Current descriptor's transfer has completed |
| rd_req_valid | output | 1 | Descriptor word read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 36 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 64 | Read response word |
| desc_load | output | 1 | One-cycle strobe: load descriptor into channel registers |
| desc_src | output | 36 | Loaded source address |
| desc_dst | output | 36 | Loaded destination address |
| desc_cnt | output | 32 | Loaded byte count |
| chain_en | output | 1 | Chain-enable status |
| xfer_act | output | 1 | Transfer-active status |
| wr_dropped | output | 1 | Pulse: a software write arrived during a fetch and was ignored |

## Verification
The chain is driven with three list shapes:
- A list started from idle whose first descriptor links onward. This separates address stepping within a fetch from the pointer update between fetches.
- A terminating descriptor with a zero next field. This shows whether the register is held rather than cleared, and whether chaining is disarmed while the channel stays active.
- A second list disarmed by a software zero write mid-transfer. This distinguishes clearing only the enable from clearing both flags.

A write injected while a word response is pending shows whether writes during a fetch are dropped and flagged.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    localparam int ALIGN_BITS = 3;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_REQ,
        ST_RSP,
        ST_LOAD
    } chain_st_e;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int FLD_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [FLD_W-1:0] sw_wr_fld,
    input  logic             fetching,
    input  logic             desc_load,
    input  logic [FLD_W-1:0] next_fld,
    input  logic             done_idle,
    output logic [FLD_W-1:0] chaddr,
    output logic             chain_en,
    output logic             xfer_act,
    output logic             wr_dropped,
    output logic             start
);
    logic accept;
    logic wr_nz;

    assign accept = sw_wr_en && !fetching;
    assign wr_nz  = |sw_wr_fld;
    assign start  = accept && wr_nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chaddr     <= '0;
            chain_en   <= 1'b0;
            xfer_act   <= 1'b0;
            wr_dropped <= 1'b0;
        end else begin
            wr_dropped <= sw_wr_en && fetching;
            if (done_idle) begin
                xfer_act <= 1'b0;
            end
            if (accept) begin
                chaddr <= sw_wr_fld;
                if (wr_nz) begin
                    chain_en <= 1'b1;
                    xfer_act <= 1'b1;
                end else begin
                    chain_en <= 1'b0;
                end
            end else if (desc_load) begin
                if (|next_fld) begin
                    chaddr <= next_fld;
                end else begin
                    chain_en <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dma_chain_desc.sv
module dma_chain_desc
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32,
    localparam int FLD_W = ADDR_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [FLD_W-1:0]  next_fld,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  cnt
);
    logic unused_hi;
    assign unused_hi = ^rsp_data[DATA_W-1:ADDR_W] ^ ^rsp_data[ALIGN_BITS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_fld <= '0;
            src      <= '0;
            dst      <= '0;
            cnt      <= '0;
        end else if (cap_en) begin
            unique case (idx)
                2'd0: next_fld <= rsp_data[ADDR_W-1:ALIGN_BITS];
                2'd1: src      <= rsp_data[ADDR_W-1:0];
                2'd2: dst      <= rsp_data[ADDR_W-1:0];
                default: cnt   <= rsp_data[CNT_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 36,
    localparam int FLD_W = ADDR_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xfer_done,
    input  logic              chain_en,
    input  logic [FLD_W-1:0]  chaddr,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    output chain_st_e         st,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic              fetching,
    output logic              desc_load,
    output logic              cap_en,
    output logic              done_idle
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    chain_st_e  st_nx;
    logic [FLD_W-1:0] word_fld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE || st == ST_RUN) begin
                idx <= '0;
            end else if (cap_en) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start)        st_nx = ST_REQ;
            ST_RUN:  if (xfer_done)    st_nx = chain_en ? ST_REQ : ST_IDLE;
            ST_REQ:  if (rd_req_ready) st_nx = ST_RSP;
            ST_RSP:  if (rd_rsp_valid) st_nx = (idx == LAST_IDX) ? ST_LOAD : ST_REQ;
            ST_LOAD:                   st_nx = ST_RUN;
            default:                   st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        word_fld     = chaddr + FLD_W'(idx);
        rd_req_addr  = {word_fld, {ALIGN_BITS{1'b0}}};
        rd_req_valid = (st == ST_REQ);
        fetching     = (st == ST_REQ) || (st == ST_RSP) || (st == ST_LOAD);
        desc_load    = (st == ST_LOAD);
        cap_en       = (st == ST_RSP) && rd_rsp_valid;
        done_idle    = (st == ST_RUN) && xfer_done && !chain_en;
    end
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [DATA_W-1:0] sw_wr_data,
    output logic [DATA_W-1:0] sw_rd_data,
    input  logic              xfer_done,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              desc_load,
    output logic [ADDR_W-1:0] desc_src,
    output logic [ADDR_W-1:0] desc_dst,
    output logic [CNT_W-1:0]  desc_cnt,
    output logic              chain_en,
    output logic              xfer_act,
    output logic              wr_dropped
);
    localparam int FLD_W = ADDR_W - ALIGN_BITS;

    chain_st_e        st;
    logic [IDX_W-1:0] idx;
    logic [FLD_W-1:0] chaddr;
    logic [FLD_W-1:0] next_fld;
    logic             fetching;
    logic             cap_en;
    logic             done_idle;
    logic             start;
    logic             unused_wr;

    assign unused_wr  = ^sw_wr_data[DATA_W-1:ADDR_W] ^ ^sw_wr_data[ALIGN_BITS-1:0];
    assign sw_rd_data = {{(DATA_W-ADDR_W){1'b0}}, chaddr, {ALIGN_BITS{1'b0}}};

    dma_chain_regs #(.FLD_W(FLD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wr_fld(sw_wr_data[ADDR_W-1:ALIGN_BITS]),
        .fetching(fetching), .desc_load(desc_load), .next_fld(next_fld),
        .done_idle(done_idle), .chaddr(chaddr), .chain_en(chain_en),
        .xfer_act(xfer_act), .wr_dropped(wr_dropped), .start(start)
    );

    dma_chain_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_done(xfer_done),
        .chain_en(chain_en), .chaddr(chaddr), .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid), .st(st), .idx(idx),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .fetching(fetching), .desc_load(desc_load), .cap_en(cap_en),
        .done_idle(done_idle)
    );

    dma_chain_desc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_desc (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx),
        .rsp_data(rd_rsp_data), .next_fld(next_fld),
        .src(desc_src), .dst(desc_dst), .cnt(desc_cnt)
    );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr_en,
    input logic [DATA_W-1:0] sw_wr_data,
    input logic [DATA_W-1:0] sw_rd_data,
    input logic              xfer_done,
    input logic              rd_req_valid,
    input logic              desc_load,
    input logic              chain_en,
    input logic              xfer_act,
    input logic              wr_dropped,
    input logic              fetching,
    input logic              next_zero
);
    logic wr_nz;
    assign wr_nz = |sw_wr_data[ADDR_W-1:3];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !chain_en && !xfer_act && !rd_req_valid) else $error("R1"); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd_data[DATA_W-1:ADDR_W] == '0 && sw_rd_data[2:0] == 3'b0); // R2

    AST_NZ_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && !fetching && wr_nz |=> chain_en && xfer_act); // R3

    AST_ZERO_WRITE_KEEPS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && !fetching && !wr_nz && !xfer_done |=> !chain_en && $stable(xfer_act)); // R4

    AST_REQ_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> xfer_act); // R5

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load |=> !desc_load); // R6

    AST_END_OF_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load && next_zero |=> !chain_en && xfer_act && $stable(sw_rd_data)); // R8

    AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !chain_en && !fetching && !sw_wr_en |=> !xfer_act); // R9

    AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && fetching && !desc_load |=> wr_dropped && $stable(sw_rd_data)); // R10
endmodule

bind dma_chain_ctrl dma_chain_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .xfer_done(xfer_done), .rd_req_valid(rd_req_valid),
    .desc_load(desc_load), .chain_en(chain_en), .xfer_act(xfer_act),
    .wr_dropped(wr_dropped), .fetching(fetching), .next_zero(next_fld == '0)
);

// File: tb/dma_chain_ctrl_test.sv
`timescale 1ns/1ps
module dma_chain_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [63:0] sw_wr_data = '0;
    logic [63:0] sw_rd_data;
    logic        xfer_done = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [35:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        desc_load;
    logic [35:0] desc_src, desc_dst;
    logic [31:0] desc_cnt;
    logic        chain_en, xfer_act, wr_dropped;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_chain_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_rd_data(sw_rd_data), .xfer_done(xfer_done), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .desc_load(desc_load), .desc_src(desc_src), .desc_dst(desc_dst),
        .desc_cnt(desc_cnt), .chain_en(chain_en), .xfer_act(xfer_act),
        .wr_dropped(wr_dropped)
    );

    localparam logic [35:0] ADR_A = 36'h1_2345_6780;
    localparam logic [35:0] ADR_B = 36'h0_00AB_CD08;
    localparam logic [35:0] ADR_C = 36'h7_0000_0100;
    localparam logic [35:0] ADR_D = 36'h7_0000_0200;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [63:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1;
        sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic serve_fetch(input string tag, input logic [35:0] base,
                               input logic [63:0] w0, input logic [63:0] w1,
                               input logic [63:0] w2, input logic [63:0] w3,
                               input bit poke);
        logic [63:0] w [4];
        logic [63:0] held;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        held = sw_rd_data;
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 50 && !rd_req_valid; n++) @(negedge clk);
            check({tag, " R5 req valid"}, {63'd0, rd_req_valid}, 64'd1);
            check({tag, " R5 req addr"}, {28'd0, rd_req_addr}, {28'd0, base + 36'(8 * k)});
            rd_req_ready = 1'b1;
            @(negedge clk);
            rd_req_ready = 1'b0;
            check({tag, " R5 one at a time"}, {63'd0, rd_req_valid}, 64'd0);
            if (poke && k == 0) begin
                sw_wr_en = 1'b1;
                sw_wr_data = 64'h0000_0005_5555_5550;
                @(negedge clk);
                sw_wr_en = 1'b0;
                check("R10 dropped flag", {63'd0, wr_dropped}, 64'd1);
                check("R10 register held", sw_rd_data, held);
                check("R10 chain_en held", {63'd0, chain_en}, 64'd1);
                @(negedge clk);
                check("R10 flag is a pulse", {63'd0, wr_dropped}, 64'd0);
            end
            rd_rsp_valid = 1'b1;
            rd_rsp_data = w[k];
            @(negedge clk);
            rd_rsp_valid = 1'b0;
        end
        check({tag, " R6 load strobe"}, {63'd0, desc_load}, 64'd1);
        check({tag, " R6 src"}, {28'd0, desc_src}, {28'd0, w1[35:0]});
        check({tag, " R6 dst"}, {28'd0, desc_dst}, {28'd0, w2[35:0]});
        check({tag, " R6 cnt"}, {32'd0, desc_cnt}, {32'd0, w3[31:0]});
        @(negedge clk);
        check({tag, " R6 strobe one cycle"}, {63'd0, desc_load}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 chain_en", {63'd0, chain_en}, 64'd0);
        check("R1 xfer_act", {63'd0, xfer_act}, 64'd0);
        check("R1 rd_req_valid", {63'd0, rd_req_valid}, 64'd0);
        check("R1 desc_load", {63'd0, desc_load}, 64'd0);
        check("R1 wr_dropped", {63'd0, wr_dropped}, 64'd0);
    endtask

    task automatic t_start_chain();
        sw_write(64'hFFFF_FFF0_0000_0007 | {28'd0, ADR_A});
        check("R2 readback masked", sw_rd_data, {28'd0, ADR_A});
        check("R3 chain_en set", {63'd0, chain_en}, 64'd1);
        check("R3 xfer_act set", {63'd0, xfer_act}, 64'd1);
        serve_fetch("d1", ADR_A, 64'hDEAD_0000_0000_0000 | {28'd0, ADR_B},
                    64'h0000_000F_1111_1110, 64'hAAAA_0002_2222_2220,
                    64'h1234_5678_0000_4000, 1'b0);
        check("R7 pointer updated", sw_rd_data, {28'd0, ADR_B});
        check("R7 chain still armed", {63'd0, chain_en}, 64'd1);
    endtask

    task automatic t_end_of_chain();
        pulse_done();
        serve_fetch("d2 R7", ADR_B, 64'hBEEF_0000_0000_0000,
                    64'h0000_0003_0000_0008, 64'h0000_0004_0000_0010,
                    64'h0000_0000_0000_0040, 1'b1);
        check("R8 pointer kept", sw_rd_data, {28'd0, ADR_B});
        check("R8 chain_en cleared", {63'd0, chain_en}, 64'd0);
        check("R8 xfer_act kept", {63'd0, xfer_act}, 64'd1);
        pulse_done();
        check("R9 xfer_act cleared", {63'd0, xfer_act}, 64'd0);
        for (int n = 0; n < 3; n++) begin
            check("R9 no request", {63'd0, rd_req_valid}, 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_sw_disarm();
        sw_write({28'd0, ADR_C});
        check("R3 restart chain_en", {63'd0, chain_en}, 64'd1);
        check("R3 restart xfer_act", {63'd0, xfer_act}, 64'd1);
        serve_fetch("d3", ADR_C, {28'd0, ADR_D}, 64'h0000_0000_0000_1000,
                    64'h0000_0000_0000_2000, 64'h0000_0000_0000_0100, 1'b0);
        check("R7 pointer to D", sw_rd_data, {28'd0, ADR_D});
        sw_write(64'hFFFF_FFF0_0000_0007);
        check("R4 chain_en cleared", {63'd0, chain_en}, 64'd0);
        check("R4 xfer_act unchanged", {63'd0, xfer_act}, 64'd1);
        check("R2 zero stored", sw_rd_data, 64'd0);
        pulse_done();
        check("R9 idle after disarm", {63'd0, xfer_act}, 64'd0);
        @(negedge clk);
        check("R9 no fetch after disarm", {63'd0, rd_req_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_chain();
        t_end_of_chain();
        t_sw_disarm();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule